// File: doc/BRIEF.md
# Shadow Stack Atomic Swap Unit

This unit carries out the atomic swap instruction that works on the shadow stack. It handles a 32-bit (word) form and a 64-bit (doubleword) form. It receives an already decoded operation along with:

- the current privilege mode;
- the shadow-stack enable bits from the machine, supervisor and hypervisor environment configuration registers;
- a flag saying whether supervisor mode exists;
- a flag saying whether the core runs with 64-bit registers.

For each accepted request the unit runs the permission and address checks in a fixed priority order. If every check passes, it does a locked read followed by a locked write to the same address on a valid/ready memory port. It then reports either the destination-register value or an exception cause in a one-cycle completion pulse.

The caller supplies an idempotency attribute for the target region together with the request, so that a non-idempotent target is rejected before any bus activity. The acquire and release bits are not interpreted. They are copied onto both memory phases as request attributes.

Top module: `ss_swap_unit`

## Requirements
- R1: Privilege checks run in this order, and the first one that matches sets the cause:
  - not M-mode with the machine enable clear gives cause 2;
  - supervisor mode not implemented gives cause 2;
  - U-mode with the supervisor enable clear gives cause 2;
  - VS-mode with the hypervisor enable clear gives cause 22;
  - VU-mode with the supervisor enable clear gives cause 22.
  
  The privilege is encoded {virtual, mode[1:0]}: U=000, S=001, M=011, VU=100, VS=101.
- R2: A doubleword request on a 32-bit core gives cause 2. This check is ranked above every R1 check.
- R3: An address not aligned to 4 bytes (word) or 8 bytes (doubleword) gives cause 7. This check is ranked below R1 and R2.
- R4: A target marked non-idempotent gives cause 7. This check is ranked below R3.
- R5: When an exception is reported, no memory request was issued for that operation. `done` rises with `done_exc`=1 and the cause, and `rd_we`=0.
- R6: A successful operation issues exactly one read and then one write, both to the request address, with `mem_lock` high in both. Each request holds its address and direction until `mem_ready`. The write follows the read handshake in the very next cycle.
- R7: A word swap stores rs2[31:0], zero-extended on `mem_wdata`, with `mem_size`=0. The rd value is the loaded low 32 bits, sign-extended on a 64-bit core and zero-extended on a 32-bit core.
- R8: A doubleword swap on a 64-bit core stores all 64 bits of rs2 with `mem_size`=1 and returns all 64 loaded bits.
- R9: With rd index 0 the store still happens and `rd_we` stays 0. With a nonzero index, a successful completion asserts `rd_we`.
- R10: The aq and rl bits of the request appear on `mem_aq`/`mem_rl` during both memory phases.
- R11: After reset the unit is idle: `req_ready`=1, `mem_valid`=0, `done`=0. `done` is a single-cycle pulse. `req_ready` is high only while no operation is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted |
| req_dword | input | 1 | 1 = doubleword form, 0 = word form |
| xlen64 | input | 1 | Core has 64-bit registers |
| priv | input | 3 | Privilege mode {virtual, mode} |
| menv_sse | input | 1 | Machine-level shadow stack enable |
| senv_sse | input | 1 | Supervisor-level shadow stack enable |
| henv_sse | input | 1 | Hypervisor-level shadow stack enable |
| s_mode_impl | input | 1 | Supervisor mode implemented |
| rs1_addr | input | ADDR_W | Target address |
| rs2_data | input | 64 | Value to store |
| rd_idx | input | 5 | Destination register index |
| aq | input | 1 | Acquire attribute |
| rl | input | 1 | Release attribute |
| tgt_idem | input | 1 | Target region is idempotent |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request taken |
| mem_write | output | 1 | 1 = write phase, 0 = read phase |
| mem_lock | output | 1 | Keeps the read and write indivisible |
| mem_size | output | 1 | 1 = 8 bytes, 0 = 4 bytes |
| mem_aq | output | 1 | Acquire attribute |
| mem_rl | output | 1 | Release attribute |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid at read handshake |
| done | output | 1 | Completion pulse |
| done_exc | output | 1 | Completion carries an exception |
| exc_cause | output | 5 | Exception cause, zero when none |
| rd_we | output | 1 | Destination write enable |
| rd_data | output | 64 | Destination value |

## Verification
The assertions assume that `priv` only carries one of the five legal encodings. They also assume that request fields are meaningful only in the accept cycle, and that the memory side returns `mem_ready` eventually. The bench keeps to these assumptions:

- it sweeps only the five defined privilege codes;
- it drives each request for exactly one accepted cycle;
- its memory model answers every request after a bounded stall of zero to two cycles, chosen per operation;
- it returns read data that depends on the address, so that extension and swap results can be told apart.

// File: rtl/ssw_pkg.sv
package ssw_pkg;

    localparam int DATA_W = 64;

    typedef enum logic [2:0] {
        PRIV_U  = 3'b000,
        PRIV_S  = 3'b001,
        PRIV_M  = 3'b011,
        PRIV_VU = 3'b100,
        PRIV_VS = 3'b101
    } priv_e;

    localparam logic [4:0] CAUSE_NONE    = 5'd0;
    localparam logic [4:0] CAUSE_ILLEGAL = 5'd2;
    localparam logic [4:0] CAUSE_ST_ACC  = 5'd7;
    localparam logic [4:0] CAUSE_VIRT    = 5'd22;

    typedef struct packed {
        logic       valid;
        logic [4:0] cause;
    } exc_t;

    typedef struct packed {
        logic dword;
        logic x64;
        logic aq;
        logic rl;
        logic rd_nz;
    } op_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } state_e;

    function automatic exc_t mk_exc(input logic [4:0] c);
        exc_t e;
        e.valid = 1'b1;
        e.cause = c;
        return e;
    endfunction

endpackage

// File: rtl/ssw_perm_check.sv
module ssw_perm_check
    import ssw_pkg::*;
(
    input  logic [2:0] priv,
    input  logic       menv_sse,
    input  logic       senv_sse,
    input  logic       henv_sse,
    input  logic       s_mode_impl,
    input  logic       dword,
    input  logic       xlen64,
    output exc_t       exc
);
    priv_e p;

    always_comb begin
        p   = priv_e'(priv);
        exc = '0;
        if (dword && !xlen64)
            exc = mk_exc(CAUSE_ILLEGAL);
        else if (p != PRIV_M && !menv_sse)
            exc = mk_exc(CAUSE_ILLEGAL);
        else if (!s_mode_impl)
            exc = mk_exc(CAUSE_ILLEGAL);
        else if (p == PRIV_U && !senv_sse)
            exc = mk_exc(CAUSE_ILLEGAL);
        else if (p == PRIV_VS && !henv_sse)
            exc = mk_exc(CAUSE_VIRT);
        else if (p == PRIV_VU && !senv_sse)
            exc = mk_exc(CAUSE_VIRT);
    end
endmodule

// File: rtl/ssw_addr_check.sv
module ssw_addr_check
    import ssw_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dword,
    input  logic              idem,
    output exc_t              exc
);
    localparam int LOW_W = 3;

    logic [LOW_W-1:0] low;
    logic             misal;

    always_comb begin
        low   = addr[LOW_W-1:0];
        misal = dword ? (low != '0) : (low[1:0] != 2'b00);
        exc   = '0;
        if (misal)
            exc = mk_exc(CAUSE_ST_ACC);
        else if (!idem)
            exc = mk_exc(CAUSE_ST_ACC);
    end
endmodule

// File: rtl/ssw_data_fmt.sv
module ssw_data_fmt
    import ssw_pkg::*;
(
    input  logic              dword,
    input  logic              xlen64,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0] st_val
);
    localparam int HALF = DATA_W / 2;

    logic [HALF-1:0] lo;
    logic [HALF-1:0] ext;

    always_comb begin
        lo  = rdata[HALF-1:0];
        ext = (xlen64 && lo[HALF-1]) ? {HALF{1'b1}} : '0;
        rd_val = dword ? rdata : {ext, lo};
        st_val = dword ? src : {{HALF{1'b0}}, src[HALF-1:0]};
    end
endmodule

// File: rtl/ss_swap_unit.sv
module ss_swap_unit
    import ssw_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_dword,
    input  logic              xlen64,
    input  logic [2:0]        priv,
    input  logic              menv_sse,
    input  logic              senv_sse,
    input  logic              henv_sse,
    input  logic              s_mode_impl,
    input  logic [ADDR_W-1:0] rs1_addr,
    input  logic [63:0]       rs2_data,
    input  logic [4:0]        rd_idx,
    input  logic              aq,
    input  logic              rl,
    input  logic              tgt_idem,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic              mem_lock,
    output logic              mem_size,
    output logic              mem_aq,
    output logic              mem_rl,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata,
    output logic              done,
    output logic              done_exc,
    output logic [4:0]        exc_cause,
    output logic              rd_we,
    output logic [63:0]       rd_data
);
    state_e            state;
    op_t               op_q;
    exc_t              exc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [63:0]       src_q;
    logic [63:0]       rd_q;

    exc_t        perm_exc;
    exc_t        addr_exc;
    exc_t        sel_exc;
    logic [63:0] rd_val;
    logic [63:0] st_val;
    logic        accept;

    ssw_perm_check u_perm (
        .priv        (priv),
        .menv_sse    (menv_sse),
        .senv_sse    (senv_sse),
        .henv_sse    (henv_sse),
        .s_mode_impl (s_mode_impl),
        .dword       (req_dword),
        .xlen64      (xlen64),
        .exc         (perm_exc)
    );

    ssw_addr_check #(.ADDR_W(ADDR_W)) u_addr (
        .addr  (rs1_addr),
        .dword (req_dword),
        .idem  (tgt_idem),
        .exc   (addr_exc)
    );

    ssw_data_fmt u_fmt (
        .dword  (op_q.dword),
        .xlen64 (op_q.x64),
        .rdata  (mem_rdata),
        .src    (src_q),
        .rd_val (rd_val),
        .st_val (st_val)
    );

    always_comb begin
        sel_exc = perm_exc.valid ? perm_exc : addr_exc;
        accept  = req_valid && (state == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= '0;
            exc_q  <= '0;
            addr_q <= '0;
            src_q  <= '0;
            rd_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_q.dword <= req_dword;
                        op_q.x64   <= xlen64;
                        op_q.aq    <= aq;
                        op_q.rl    <= rl;
                        op_q.rd_nz <= (rd_idx != 5'd0);
                        exc_q      <= sel_exc;
                        addr_q     <= rs1_addr;
                        src_q      <= rs2_data;
                        rd_q       <= '0;
                        state      <= sel_exc.valid ? ST_DONE : ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        rd_q  <= rd_val;
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ready)
                        state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_valid = (state == ST_READ) || (state == ST_WRITE);
        mem_write = (state == ST_WRITE);
        mem_lock  = mem_valid;
        mem_size  = op_q.dword;
        mem_aq    = mem_valid && op_q.aq;
        mem_rl    = mem_valid && op_q.rl;
        mem_addr  = addr_q;
        mem_wdata = st_val;
        done      = (state == ST_DONE);
        done_exc  = done && exc_q.valid;
        exc_cause = done_exc ? exc_q.cause : CAUSE_NONE;
        rd_we     = done && !exc_q.valid && op_q.rd_nz;
        rd_data   = rd_q;
    end
endmodule

// File: rtl/ssw_checker.sv
module ssw_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_write,
    input logic              mem_lock,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              done_exc,
    input logic              rd_we
);
    logic touched;
    logic read_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            touched   <= 1'b0;
            read_seen <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                touched   <= 1'b0;
                read_seen <= 1'b0;
            end else begin
                if (mem_valid)
                    touched <= 1'b1;
                if (mem_valid && mem_ready && !mem_write)
                    read_seen <= 1'b1;
            end
        end
    end

    assert_exc_no_mem_R5: assert property (@(posedge clk) disable iff (rst)
        (done && done_exc) |-> !touched);

    assert_hold_req_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

    assert_write_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write) |-> read_seen);

    assert_locked_pair_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && !mem_write) |=> (mem_valid && mem_write && mem_lock));

    assert_rdwe_ok_R9: assert property (@(posedge clk) disable iff (rst)
        rd_we |-> (done && !done_exc));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_valid);
endmodule

bind ss_swap_unit ssw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_lock  (mem_lock),
    .mem_addr  (mem_addr),
    .done      (done),
    .done_exc  (done_exc),
    .rd_we     (rd_we)
);

// File: tb/tb_ss_swap_unit.sv
module tb_ss_swap_unit;
    localparam int AW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_dword = 1'b0;
    logic          xlen64 = 1'b0;
    logic [2:0]    priv = 3'b011;
    logic          menv_sse = 1'b0, senv_sse = 1'b0, henv_sse = 1'b0, s_mode_impl = 1'b0;
    logic [AW-1:0] rs1_addr = '0;
    logic [63:0]   rs2_data = '0;
    logic [4:0]    rd_idx = '0;
    logic          aq = 1'b0, rl = 1'b0, tgt_idem = 1'b0;
    logic          mem_valid, mem_ready = 1'b0, mem_write, mem_lock, mem_size, mem_aq, mem_rl;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata, mem_rdata = '0;
    logic          done, done_exc, rd_we;
    logic [4:0]    exc_cause;
    logic [63:0]   rd_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ss_swap_unit #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_dword(req_dword), .xlen64(xlen64), .priv(priv),
        .menv_sse(menv_sse), .senv_sse(senv_sse), .henv_sse(henv_sse),
        .s_mode_impl(s_mode_impl), .rs1_addr(rs1_addr), .rs2_data(rs2_data),
        .rd_idx(rd_idx), .aq(aq), .rl(rl), .tgt_idem(tgt_idem),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_lock(mem_lock), .mem_size(mem_size), .mem_aq(mem_aq), .mem_rl(mem_rl),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .done_exc(done_exc), .exc_cause(exc_cause),
        .rd_we(rd_we), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_cause(input logic [2:0] p, input bit m, input bit s,
            input bit h, input bit si, input bit dw, input bit x64,
            input logic [2:0] lo, input bit idem);
        if (dw && !x64) return 5'd2;                       // R2
        if (p != 3'b011 && !m) return 5'd2;                // R1
        if (!si) return 5'd2;
        if (p == 3'b000 && !s) return 5'd2;
        if (p == 3'b101 && !h) return 5'd22;
        if (p == 3'b100 && !s) return 5'd22;
        if (dw ? (lo != 3'd0) : (lo[1:0] != 2'd0)) return 5'd7; // R3
        if (!idem) return 5'd7;                            // R4
        return 5'd0;
    endfunction

    function automatic logic [63:0] mem_pattern(input logic [AW-1:0] a, input int n);
        logic [31:0] lo;
        lo = a[31:0] ^ 32'h0000_0F0F ^ ((n % 2 == 1) ? 32'h8000_0000 : 32'h0);
        return {a[31:0] ^ 32'h8000_0001, lo};
    endfunction

    task automatic run_op(input int n, input logic [2:0] p, input bit m, input bit s,
            input bit h, input bit si, input bit dw, input bit x64,
            input logic [2:0] off, input bit idem);
        logic [4:0]    ec;
        logic [AW-1:0] a;
        logic [63:0]   src, rdat, exp_rd, exp_wd;
        int            hs, stall, waitc, cyc;
        bit            fin, lock_ok, addr_ok, attr_ok, order_ok, size_ok, wd_ok;
        logic [4:0]    got_cause;
        logic          got_exc, got_we;
        logic [63:0]   got_rd, got_wd;

        a     = 64'h0000_0001_0000_0000 + (AW'(n) << 4) + AW'(off);
        src   = {32'hC0DE_0000 ^ 32'(n), 32'(n) * 32'h9E37_79B9};
        ec    = exp_cause(p, m, s, h, si, dw, x64, off, idem);
        stall = n % 3;
        rdat  = mem_pattern(a, n);

        @(negedge clk);
        req_valid = 1'b1; priv = p; menv_sse = m; senv_sse = s; henv_sse = h;
        s_mode_impl = si; req_dword = dw; xlen64 = x64; rs1_addr = a;
        rs2_data = src; rd_idx = 5'(n % 7); aq = n[0]; rl = n[1]; tgt_idem = idem;
        @(negedge clk);
        req_valid = 1'b0;

        hs = 0; waitc = 0; fin = 0; got_wd = '0;
        lock_ok = 1; addr_ok = 1; attr_ok = 1; order_ok = 1; size_ok = 1;
        got_cause = '0; got_exc = 0; got_we = 0; got_rd = '0;
        for (cyc = 0; cyc < 40 && !fin; cyc++) begin
            if (done) begin
                fin = 1;
                got_exc = done_exc; got_cause = exc_cause; got_we = rd_we; got_rd = rd_data;
                mem_ready = 1'b0;
            end else begin
                mem_ready = 1'b0;
                if (mem_valid) begin
                    if (waitc >= stall) begin
                        mem_ready = 1'b1;
                        mem_rdata = mem_pattern(mem_addr, n);
                        if (!mem_lock) lock_ok = 0;
                        if (mem_addr != a) addr_ok = 0;
                        if (mem_aq != n[0] || mem_rl != n[1]) attr_ok = 0;
                        if (mem_size != dw) size_ok = 0;
                        if ((hs == 0 && mem_write) || (hs == 1 && !mem_write) || hs > 1) order_ok = 0;
                        if (mem_write) got_wd = mem_wdata;
                        hs++;
                        waitc = 0;
                    end else begin
                        waitc++;
                    end
                end
                @(negedge clk);
            end
        end
        mem_ready = 1'b0;

        check(fin, "R11", "completion seen", 64'(fin), 64'd1);
        check(got_cause == ec, (ec == 5'd7) ? "R3/R4" : "R1/R2", "cause",
              64'(got_cause), 64'(ec));
        check(got_exc == (ec != 5'd0), "R5", "exception flag", 64'(got_exc), 64'(ec != 5'd0));
        if (ec != 5'd0) begin
            check(hs == 0, "R5", "no memory access", 64'(hs), 64'd0);
            check(!got_we, "R5", "rd_we on exception", 64'(got_we), 64'd0);
        end else begin
            exp_wd = dw ? src : {32'h0, src[31:0]};
            if (dw) exp_rd = rdat;
            else if (x64) exp_rd = {{32{rdat[31]}}, rdat[31:0]};
            else exp_rd = {32'h0, rdat[31:0]};
            check(hs == 2 && order_ok, "R6", "read then write", 64'(hs), 64'd2);
            check(lock_ok && addr_ok, "R6", "lock and address", 64'(lock_ok & addr_ok), 64'd1);
            check(attr_ok, "R10", "aq/rl forwarded", 64'(attr_ok), 64'd1);
            check(size_ok, dw ? "R8" : "R7", "size", 64'(size_ok), 64'd1);
            check(got_wd == exp_wd, dw ? "R8" : "R7", "store data", got_wd, exp_wd);
            check(got_we == (n % 7 != 0), "R9", "rd_we", 64'(got_we), 64'(n % 7 != 0));
            if (got_we)
                check(got_rd == exp_rd, dw ? "R8" : "R7", "rd value", got_rd, exp_rd);
        end
        @(negedge clk);
        check(!done && req_ready, "R11", "pulse ends, idle", 64'(done), 64'd0);
    endtask

    initial begin
        logic [2:0] pcodes [5];
        logic [2:0] offs [3];
        int n;
        pcodes[0] = 3'b000; pcodes[1] = 3'b001; pcodes[2] = 3'b011;
        pcodes[3] = 3'b100; pcodes[4] = 3'b101;
        offs[0] = 3'd0; offs[1] = 3'd4; offs[2] = 3'd2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !mem_valid && !done, "R11", "reset state",
              {61'd0, req_ready, mem_valid, done}, 64'd4);
        n = 0;
        for (int pi = 0; pi < 5; pi++)
            for (int cfg = 0; cfg < 16; cfg++)
                for (int f = 0; f < 4; f++)
                    for (int oi = 0; oi < 3; oi++)
                        for (int id = 0; id < 2; id++) begin
                            run_op(n, pcodes[pi], cfg[0], cfg[1], cfg[2], cfg[3],
                                   f[0], f[1], offs[oi], id[0]);
                            n++;
                        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule